// File: doc/BRIEF.md
# Lane-split half-to-single widening converter

This block widens IEEE half-precision values to single precision inside a 256-bit vector. The vector is treated as two independent 128-bit lanes. Each lane produces four 32-bit results, and a single select input decides whether they come from the lower or the upper four halfwords of that same lane. The halfwords are never drawn from across the whole register. Each element converts exactly: normals, subnormals, infinities, signed zeros and NaNs all map to single precision with no rounding. The only exception that can arise is invalid, which a signalling NaN raises.

An operation starts when `valid_i` is high on a clock edge. All eight elements are converted in parallel into a staging vector that starts from zero. The full vector is then registered in one step, together with the exception flags of that operation. The flags are cleared at the start of each operation and are the OR of the flags that the eight converted elements raise.

A two-state machine tracks the handshake:
- **IDLE**: no result was produced last cycle.
- **DONE**: a result was registered at the last edge, so `done_o` is high.

The transitions are:
- **accept**: IDLE to DONE on `valid_i`.
- **chain**: DONE to DONE on `valid_i`.
- **retire**: DONE to IDLE without `valid_i`.
- **wait**: IDLE to IDLE without `valid_i`.

In the surrounding decoder, the low and high forms of the operation differ only in the least significant bit of their minor opcode field. That bit drives `hi_sel_i` directly.

Top module: `h2s_widen`

## Requirements
- R1: With `hi_sel_i`=0, result element j of lane i (bits [32*(4i+j)+:32], i=0..1, j=0..3) is the conversion of source halfword 8i+j (bits [16*k+:16] for halfword k).
- R2: With `hi_sel_i`=1, result element j of lane i is the conversion of source halfword 8i+j+4.
- R3: A normal half value (exponent 1..30) converts exactly: same sign, exponent plus 112, mantissa in the top 10 fraction bits with 13 zero bits below, and no flag.
- R4: A subnormal half value (exponent 0, mantissa nonzero) is normalised into an exact normal single value, and no flag is raised.
- R5: Zeros and infinities keep their sign and convert to single-precision zero or infinity, with no flag.
- R6: A NaN input gives sign kept, exponent 255, fraction bit 22 set, the low nine mantissa bits in fraction bits 21:13, and zeros below. A signalling NaN (mantissa bit 9 clear) raises invalid; a quiet NaN raises nothing.
- R7: `flags_o` bit 0 is invalid and bits 4:1 (divide-by-zero, overflow, underflow, inexact) are always 0. The flags of each operation start from zero and OR only the eight selected elements; unselected halfwords have no effect.
- R8: `done_o` is high exactly in the cycle after an edge with `valid_i` high. `result_o` and `flags_o` change only at such edges.
- R9: After reset `done_o` is 0, `result_o` is all zeros and `flags_o` is 0.
- R10: Operations on consecutive cycles each produce their own result, and `done_o` stays high across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Start an operation on this edge |
| hi_sel_i | input | 1 | 0 selects the lower, 1 the upper halfwords of each lane |
| src_i | input | 256 | Sixteen half-precision source elements |
| result_o | output | 256 | Eight single-precision results |
| done_o | output | 1 | Result and flags of the last operation are valid |
| flags_o | output | 5 | Exception flags of the last operation, bit 0 invalid |

## Verification
Two functions can meet in one cycle. One is the flag accumulation over the selected elements, which must ignore the unselected halfwords. The other is a new operation being accepted while the previous result is still presented. The bench sweeps all 65536 half codes in batches of sixteen, one code per halfword, so signalling NaNs land in selected and unselected positions alike. Each batch is issued as a low operation immediately followed by a high one. Each result and flag vector is judged against values computed arithmetically from the batch, and `done_o` must stay high through the chained pair and drop afterwards.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
    localparam int HALF_W   = 16;
    localparam int SINGLE_W = 32;
    localparam int FLAG_W   = 5;
    localparam int FLAG_NV  = 0;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;
endpackage

// File: rtl/h2s_elem.sv
module h2s_elem
    import h2s_pkg::*;
(
    input  logic [HALF_W-1:0]   half_i,
    output logic [SINGLE_W-1:0] single_o,
    output logic                invalid_o
);
    logic       sgn;
    logic [4:0] hexp;
    logic [9:0] hman;
    logic [3:0] top_bit;
    logic [9:0] sub_frac;
    logic [7:0] sub_exp;

    assign sgn  = half_i[15];
    assign hexp = half_i[14:10];
    assign hman = half_i[9:0];

    // position of the highest set mantissa bit, used for subnormals
    always_comb begin
        top_bit = 4'd0;
        for (int b = 0; b < 10; b++) begin
            if (hman[b]) top_bit = b[3:0];
        end
    end

    assign sub_frac = 10'(hman << (4'd10 - top_bit));
    assign sub_exp  = 8'd103 + {4'd0, top_bit};

    always_comb begin
        invalid_o = 1'b0;
        if (hexp == 5'd0) begin
            if (hman == 10'd0) single_o = {sgn, 31'd0};
            else               single_o = {sgn, sub_exp, sub_frac, 13'd0};
        end else if (hexp == 5'd31) begin
            if (hman == 10'd0) begin
                single_o = {sgn, 8'hFF, 23'd0};
            end else begin
                single_o  = {sgn, 8'hFF, 1'b1, hman[8:0], 13'd0};
                invalid_o = ~hman[9];
            end
        end else begin
            single_o = {sgn, 8'({3'd0, hexp}) + 8'd112, hman, 13'd0};
        end
    end
endmodule

// File: rtl/h2s_lane.sv
module h2s_lane
    import h2s_pkg::*;
#(
    parameter int LANE_BITS = 128,
    localparam int ELEMS    = LANE_BITS / (2 * HALF_W),
    localparam int OUT_BITS = ELEMS * SINGLE_W
) (
    input  logic [LANE_BITS-1:0] lane_i,
    input  logic                 hi_sel_i,
    output logic [OUT_BITS-1:0]  lane_o,
    output logic                 invalid_o
);
    logic [ELEMS-1:0] elem_nv;

    for (genvar j = 0; j < ELEMS; j++) begin : g_elem
        logic [HALF_W-1:0] pick;
        assign pick = hi_sel_i ? lane_i[HALF_W*(j+ELEMS) +: HALF_W]
                               : lane_i[HALF_W*j +: HALF_W];
        h2s_elem u_elem (
            .half_i    (pick),
            .single_o  (lane_o[SINGLE_W*j +: SINGLE_W]),
            .invalid_o (elem_nv[j])
        );
    end

    assign invalid_o = |elem_nv;
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
    import h2s_pkg::*;
#(
    parameter int LANES     = 2,
    parameter int LANE_BITS = 128,
    localparam int VEC_BITS = LANES * LANE_BITS
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                valid_i,
    input  logic                hi_sel_i,
    input  logic [VEC_BITS-1:0] src_i,
    output logic [VEC_BITS-1:0] result_o,
    output logic                done_o,
    output logic [FLAG_W-1:0]   flags_o
);
    state_e state_q, state_d;

    logic [VEC_BITS-1:0] lane_res;
    logic [LANES-1:0]    lane_nv;
    logic [VEC_BITS-1:0] staging;
    logic [FLAG_W-1:0]   cause;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        h2s_lane #(.LANE_BITS(LANE_BITS)) u_lane (
            .lane_i    (src_i[LANE_BITS*i +: LANE_BITS]),
            .hi_sel_i  (hi_sel_i),
            .lane_o    (lane_res[LANE_BITS*i +: LANE_BITS]),
            .invalid_o (lane_nv[i])
        );
    end

    // staging starts from zero each operation; cause flags cleared likewise
    always_comb begin
        staging = '0;
        staging = lane_res;
        cause   = '0;
        cause[FLAG_NV] = |lane_nv;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (valid_i)  state_d = ST_DONE;
            ST_DONE: if (!valid_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_o <= '0;
            flags_o  <= '0;
        end else if (valid_i) begin
            result_o <= staging;
            flags_o  <= cause;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_DONE: done_o = 1'b1;
            default: done_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/h2s_widen_chk.sv
module h2s_widen_chk
    import h2s_pkg::*;
#(
    parameter int VEC_BITS = 256
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                valid_i,
    input logic [VEC_BITS-1:0] result_o,
    input logic                done_o,
    input logic [FLAG_W-1:0]   flags_o
);
    localparam int NRES = VEC_BITS / SINGLE_W;

    logic any_nan;
    always_comb begin
        any_nan = 1'b0;
        for (int k = 0; k < NRES; k++) begin
            if (result_o[SINGLE_W*k+23 +: 8] == 8'hFF &&
                result_o[SINGLE_W*k +: 23] != 23'd0)
                any_nan = 1'b1;
        end
    end

    // R8
    done_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> done_o);

    // R8
    no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !done_o);

    // R8
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o) && $stable(flags_o));

    // R7
    spare_flags_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[4:1] == 4'd0);

    // R6
    invalid_has_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && flags_o[FLAG_NV]) |-> any_nan);
endmodule

bind h2s_widen h2s_widen_chk #(.VEC_BITS(VEC_BITS)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .result_o (result_o),
    .done_o   (done_o),
    .flags_o  (flags_o)
);

// File: tb/h2s_widen_tb.sv
`timescale 1ns/1ps
module h2s_widen_tb;
    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         valid_i = 1'b0;
    logic         hi_sel_i = 1'b0;
    logic [255:0] src_i = '0;
    logic [255:0] result_o;
    logic         done_o;
    logic [4:0]   flags_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    h2s_widen u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .hi_sel_i(hi_sel_i),
        .src_i(src_i), .result_o(result_o), .done_o(done_o), .flags_o(flags_o)
    );

    always #5 clk_i = ~clk_i;

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // arithmetic model: shift-until-normal formulation
    function automatic logic [31:0] ref_cvt(input logic [15:0] h);
        logic       s;
        int         e;
        logic [10:0] m;
        s = h[15];
        e = int'(h[14:10]);
        m = {1'b0, h[9:0]};
        if (e == 0 && m == 0) return {s, 31'd0};
        if (e == 31 && m == 0) return {s, 8'hFF, 23'd0};
        if (e == 31) return {s, 8'hFF, 1'b1, m[8:0], 13'd0};
        if (e == 0) begin
            e = 113;
            while (m[10] == 1'b0) begin
                m = m << 1;
                e = e - 1;
            end
            return {s, 8'(e), m[9:0], 13'd0};
        end
        return {s, 8'(e + 112), m[9:0], 13'd0};
    endfunction

    function automatic bit is_snan(input logic [15:0] h);
        return h[14:10] == 5'd31 && h[9:0] != 10'd0 && !h[9];
    endfunction

    function automatic string cls_tag(input logic [15:0] h);
        if (h[14:10] == 5'd31 && h[9:0] != 0) return "R6";
        if (h[14:10] == 5'd31 || h[14:0] == 0) return "R5";
        if (h[14:10] == 5'd0) return "R4";
        return "R3";
    endfunction

    task automatic check_op(input logic [255:0] src, input bit hi);
        logic [4:0] exp_flags;
        exp_flags = 5'd0;
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 4; j++) begin
                int k;
                logic [15:0] h;
                logic [31:0] got;
                k   = 8 * i + j + (hi ? 4 : 0);
                h   = src[16*k +: 16];
                got = result_o[32*(4*i+j) +: 32];
                if (is_snan(h)) exp_flags[0] = 1'b1;
                checks++;
                if (got !== ref_cvt(h)) begin
                    errors++;
                    $display("FAIL %s/%s lane %0d elem %0d half %h: actual %h expected %h",
                             hi ? "R2" : "R1", cls_tag(h), i, j, h, got, ref_cvt(h));
                end
            end
        end
        checks++;
        if (flags_o !== exp_flags) begin
            errors++;
            $display("FAIL R7 flags: actual %b expected %b", flags_o, exp_flags);
        end
    endtask

    task automatic check_done(input logic exp, input string tag);
        checks++;
        if (done_o !== exp) begin
            errors++;
            $display("FAIL %s done: actual %b expected %b", tag, done_o, exp);
        end
    endtask

    initial begin
        logic [255:0] batch;
        logic [255:0] held;
        // R9 reset state
        #23;
        checks++;
        if (result_o !== '0 || flags_o !== '0 || done_o !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: actual %h/%b/%b expected 0/0/0", result_o, flags_o, done_o);
        end
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check_done(1'b0, "R9");

        for (int b = 0; b < 4096; b++) begin
            for (int k = 0; k < 16; k++) batch[16*k +: 16] = 16'(b * 16 + k);
            // low operation
            src_i = batch; hi_sel_i = 1'b0; valid_i = 1'b1;
            @(negedge clk_i);
            check_done(1'b1, "R8");
            check_op(batch, 1'b0);
            // high operation right behind it
            hi_sel_i = 1'b1;
            @(negedge clk_i);
            check_done(1'b1, "R10");
            check_op(batch, 1'b1);
            valid_i = 1'b0;
            @(negedge clk_i);
            check_done(1'b0, "R8");
        end

        // R8: outputs hold while idle even as inputs change
        held = result_o;
        src_i = ~src_i; hi_sel_i = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        checks++;
        if (result_o !== held) begin
            errors++;
            $display("FAIL R8 hold: actual %h expected %h", result_o, held);
        end

        // R7: signalling NaN only in unselected halfwords, low select
        batch = '0;
        for (int k = 0; k < 16; k++) batch[16*k +: 16] = ((k % 8) >= 4) ? 16'h7C01 : 16'h3C00;
        src_i = batch; hi_sel_i = 1'b0; valid_i = 1'b1;
        @(negedge clk_i);
        valid_i = 1'b0;
        check_op(batch, 1'b0);
        // then a flagged op followed by a clean one: flags must clear
        src_i = batch; hi_sel_i = 1'b1; valid_i = 1'b1;
        @(negedge clk_i);
        check_op(batch, 1'b1);
        hi_sel_i = 1'b0;
        @(negedge clk_i);
        valid_i = 1'b0;
        check_op(batch, 1'b0);
        @(negedge clk_i);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule